// File: doc/BRIEF.md
# Converter Host Read/Start Interface

This block connects an 8-bit processor bus to the sequencer of a successive-approximation converter. The host drives two active-low strobes, a select and a read. When both are low together they open the data bus, which shows the result latch, and, in the synchronous styles, they ask for a new conversion. An active-low busy output is low while a conversion runs. The sequencer reports completion with a one-cycle done pulse and the new code.

The same logic serves three ways of working. In wait-state style the host holds the strobes low through the whole conversion and takes the new code when busy returns high. In ROM style every read returns the code already in the latch and starts the next conversion. With the mode input low the block starts conversions on its own, back to back. There the strobes only read. A read that is still active when a conversion completes holds the new code back and parks the converter until the read ends.

The strobes pass through a two-flop synchroniser before edge detection. The output-enable decode uses the raw pins.

Top module: `adc_host_if`

## Requirements
- R1: After reset the result latch reads 0x00, busy_no is high, and in synchronous mode (cont_mode_ni high) no conversion starts until a read arrives.
- R2: bus_oe_o is high only while both cs_ni and rd_ni are low. bus_o always presents the result latch.
- R3: rd_ni low while cs_ni is high starts nothing.
- R4: In synchronous mode, a read that begins while idle returns the latch contents as they stood before it and starts one conversion. busy_no goes low, and after completion the latch holds the new code.
- R5: With the strobes held low through a conversion, the latch shows the new code at the first sample after busy_no returns high, while bus_oe_o is still high.
- R6: A read whose synchronised edge is seen fewer than GUARD_CYC clock cycles after busy_no rose starts no conversion. With SYNC_STAGES=2 and GUARD_CYC=4, strobes dropped d cycles after busy_no rises start a conversion only when d+2 >= 4.
- R7: A read during a running conversion returns the previous code and starts no further conversion.
- R8: With cont_mode_ni low and no read, conversions run back to back, and the latch takes each new code as busy_no rises.
- R9: In continuous mode, a read active when a conversion completes keeps the old code in the latch and holds busy_no high with no new start. When the read ends, the deferred code loads and the next conversion starts.
- R10: conv_start_o is a single-cycle pulse, and busy_no is already low in that cycle. No start occurs while busy_no is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select strobe, active low |
| rd_ni | input | 1 | Read strobe, active low |
| cont_mode_ni | input | 1 | Low selects continuous conversion |
| conv_done_i | input | 1 | One-cycle completion pulse from sequencer |
| result_i | input | DATA_W | Code from sequencer, valid with conv_done_i |
| conv_start_o | output | 1 | One-cycle start request to sequencer |
| busy_no | output | 1 | Low while a conversion runs |
| bus_o | output | DATA_W | Result latch towards the bus drivers |
| bus_oe_o | output | 1 | Enable for the tri-state bus drivers |

## Verification
The hardest case to reach is the collision at the end of a continuous conversion: the read has to be active, already through the synchroniser, in the cycle the done pulse arrives. The bench waits for busy_no to fall and then lowers both strobes well inside the conversion window, so the read is certainly active at completion. A sweep then covers the restart guard. It drops the strobes 0 to 5 cycles after busy_no rises, which places the synchronised edge on both sides of the guard boundary.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  typedef struct packed {
    logic cs_n;
    logic rd_n;
  } strobe_t;
endpackage

// File: rtl/host_sync.sv
module host_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] q_q;

  // strobes are inactive high, so reset to all ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '1;
    else         q_q <= {q_q[STAGES-2:0], d_i};
  end

  assign q_o = q_q[STAGES-1];
endmodule

// File: rtl/host_ctrl.sv
module host_ctrl #(
  parameter int unsigned GUARD_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_act_i,
  input  logic cont_n_i,
  input  logic done_i,
  input  logic stall_i,
  output logic done_ok_o,
  output logic busy_o,
  output logic start_o
);
  localparam int unsigned CW = $clog2(GUARD_CYC + 1);

  logic          act_q, busy_q, start_q;
  logic [CW-1:0] since_q;
  logic          read_rise, guard_ok, start_fire;

  assign read_rise  = rd_act_i & ~act_q;
  assign guard_ok   = (since_q >= CW'(GUARD_CYC));
  assign done_ok_o  = busy_q & done_i;
  assign start_fire = ~busy_q & ((~cont_n_i & ~stall_i) |
                                 (cont_n_i & read_rise & guard_ok));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      since_q <= CW'(GUARD_CYC);
    end else begin
      act_q   <= rd_act_i;
      start_q <= start_fire;
      if (start_fire)     busy_q <= 1'b1;
      else if (done_ok_o) busy_q <= 1'b0;
      // cycles since end of conversion, saturating at the guard
      if (done_ok_o)                    since_q <= '0;
      else if (since_q < CW'(GUARD_CYC)) since_q <= since_q + CW'(1);
    end
  end

  assign busy_o  = busy_q;
  assign start_o = start_q;
endmodule

// File: rtl/result_latch.sv
module result_latch #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_ok_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              rd_act_i,
  input  logic              cont_n_i,
  output logic [DATA_W-1:0] data_o,
  output logic              pend_o
);
  logic [DATA_W-1:0] data_q, shadow_q;
  logic              pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= '0;
      shadow_q <= '0;
      pend_q   <= 1'b0;
    end else if (done_ok_i) begin
      if (!cont_n_i && rd_act_i) begin
        shadow_q <= result_i;
        pend_q   <= 1'b1;
      end else begin
        data_q   <= result_i;
      end
    end else if (pend_q && !rd_act_i) begin
      data_q <= shadow_q;
      pend_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/adc_host_if.sv
module adc_host_if
  import adc_host_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned GUARD_CYC   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              cont_mode_ni,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              conv_start_o,
  output logic              busy_no,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o
);
  localparam int unsigned SW = $bits(strobe_t);

  strobe_t raw, syn;
  logic    rd_act, pend, done_ok, busy;

  assign raw.cs_n = cs_ni;
  assign raw.rd_n = rd_ni;

  host_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign rd_act = ~syn.cs_n & ~syn.rd_n;

  host_ctrl #(.GUARD_CYC(GUARD_CYC)) ctrl_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_act_i (rd_act),
    .cont_n_i (cont_mode_ni),
    .done_i   (conv_done_i),
    .stall_i  (pend),
    .done_ok_o(done_ok),
    .busy_o   (busy),
    .start_o  (conv_start_o)
  );

  result_latch #(.DATA_W(DATA_W)) latch_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_ok_i(done_ok),
    .result_i (result_i),
    .rd_act_i (rd_act),
    .cont_n_i (cont_mode_ni),
    .data_o   (bus_o),
    .pend_o   (pend)
  );

  // output enable follows raw pins: no synchroniser latency on the bus
  assign bus_oe_o = ~cs_ni & ~rd_ni;
  assign busy_no  = ~busy;
endmodule

// File: rtl/adc_host_if_chk.sv
module adc_host_if_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cont_mode_ni,
  input logic              conv_done_i,
  input logic              conv_start_o,
  input logic              busy_no,
  input logic [DATA_W-1:0] bus_o,
  input logic              rd_act,
  input logic              pend
);
  // R10
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);
  // R10
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> !busy_no);
  // R7
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_no && !conv_done_i) |=> !conv_start_o);
  // R7
  bus_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!conv_done_i && !pend) |=> $stable(bus_o));
  // R9
  defer_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cont_mode_ni && conv_done_i && !busy_no && rd_act) |=> (busy_no && $stable(bus_o)));
  // R9
  stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend |-> (!conv_start_o && busy_no));
endmodule

bind adc_host_if adc_host_if_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cont_mode_ni(cont_mode_ni),
  .conv_done_i (conv_done_i),
  .conv_start_o(conv_start_o),
  .busy_no     (busy_no),
  .bus_o       (bus_o),
  .rd_act      (rd_act),
  .pend        (pend)
);

// File: tb/adc_host_if_tb_top.sv
module adc_host_if_tb_top;
  localparam int CONV  = 12;
  localparam int SYNC  = 2;
  localparam int GUARD = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, rd_ni = 1'b1, cont_mode_ni = 1'b1;
  logic       conv_done_i;
  logic [7:0] result_i;
  logic       conv_start_o, busy_no, bus_oe_o;
  logic [7:0] bus_o;

  int n_checks = 0, n_fail = 0;
  int conv_num, seq_cnt;
  logic [7:0] latch_exp;

  always #4 clk_i = ~clk_i;

  adc_host_if dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .rd_ni(rd_ni),
    .cont_mode_ni(cont_mode_ni), .conv_done_i(conv_done_i), .result_i(result_i),
    .conv_start_o(conv_start_o), .busy_no(busy_no), .bus_o(bus_o), .bus_oe_o(bus_oe_o)
  );

  function automatic logic [7:0] val(input int k);
    return 8'((k * 37 + 5) % 256);
  endfunction

  // sequencer model
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_done_i <= 1'b0; result_i <= 8'h00; conv_num <= 0; seq_cnt <= 0;
    end else begin
      conv_done_i <= 1'b0;
      if (conv_start_o) begin
        conv_num <= conv_num + 1;
        seq_cnt  <= CONV;
      end else if (seq_cnt != 0) begin
        seq_cnt <= seq_cnt - 1;
        if (seq_cnt == 1) begin
          conv_done_i <= 1'b1;
          result_i    <= val(conv_num);
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    int t = 0;
    @(negedge clk_i);
    while (!busy_no && t < 200) begin @(negedge clk_i); t++; end
    chk("R10 idle timeout", int'(busy_no), 1);
  endtask

  task automatic wait_busy();
    int t = 0;
    @(negedge clk_i);
    while (busy_no && t < 200) begin @(negedge clk_i); t++; end
    chk("R8 busy timeout", int'(busy_no), 0);
  endtask

  // ROM-style read: check previous code, start pulse, busy
  task automatic rom_read(input logic [7:0] prev);
    int n0 = conv_num;
    cs_ni = 1'b0; rd_ni = 1'b0;
    @(negedge clk_i);
    chk("R2 oe during read", int'(bus_oe_o), 1);
    chk("R4 prev code", int'(bus_o), int'(prev));
    repeat (2) @(negedge clk_i);
    chk("R10 start pulse", int'(conv_start_o), 1);
    chk("R10 busy at start", int'(busy_no), 0);
    @(negedge clk_i);
    chk("R10 single pulse", int'(conv_start_o), 0);
    chk("R4 one start", conv_num, n0 + 1);
    cs_ni = 1'b1; rd_ni = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 latch", int'(bus_o), 0);
    chk("R1 busy", int'(busy_no), 1);
    repeat (10) @(negedge clk_i);
    chk("R1 no start", conv_num, 0);

    // strobe decode
    cs_ni = 1'b0; #1; chk("R2 cs only", int'(bus_oe_o), 0);
    cs_ni = 1'b1; rd_ni = 1'b0; #1; chk("R2 rd only", int'(bus_oe_o), 0);
    repeat (8) @(negedge clk_i);
    chk("R3 rd without cs", conv_num, 0);
    chk("R3 busy", int'(busy_no), 1);
    cs_ni = 1'b0; #1; chk("R2 both low", int'(bus_oe_o), 1);
    cs_ni = 1'b1; rd_ni = 1'b1;
    latch_exp = 8'h00;

    // ROM style
    for (int k = 1; k <= 4; k++) begin
      repeat (10) @(negedge clk_i);
      rom_read(latch_exp);
      wait_idle();
      latch_exp = val(conv_num);
      chk("R4 new code", int'(bus_o), int'(latch_exp));
    end

    // guard sweep
    for (int d = 0; d <= 5; d++) begin
      int n0;
      repeat (10) @(negedge clk_i);
      rom_read(latch_exp);
      wait_idle();
      latch_exp = val(conv_num);
      repeat (d) @(negedge clk_i);
      n0 = conv_num;
      cs_ni = 1'b0; rd_ni = 1'b0;
      repeat (5) @(negedge clk_i);
      cs_ni = 1'b1; rd_ni = 1'b1;
      chk($sformatf("R6 guard d=%0d", d), conv_num, n0 + ((d + SYNC >= GUARD) ? 1 : 0));
      if (d + SYNC >= GUARD) begin
        wait_idle();
        latch_exp = val(conv_num);
      end
      chk("R6 latch", int'(bus_o), int'(latch_exp));
    end

    // read during conversion
    begin
      int n0;
      repeat (10) @(negedge clk_i);
      n0 = conv_num;
      rom_read(latch_exp);
      repeat (2) @(negedge clk_i);
      cs_ni = 1'b0; rd_ni = 1'b0;
      @(negedge clk_i);
      chk("R7 old code mid-conversion", int'(bus_o), int'(latch_exp));
      repeat (4) @(negedge clk_i);
      cs_ni = 1'b1; rd_ni = 1'b1;
      wait_idle();
      latch_exp = val(conv_num);
      repeat (10) @(negedge clk_i);
      chk("R7 no extra start", conv_num, n0 + 1);
      chk("R7 code", int'(bus_o), int'(latch_exp));
    end

    // wait-state style
    begin
      int n0;
      repeat (10) @(negedge clk_i);
      n0 = conv_num;
      cs_ni = 1'b0; rd_ni = 1'b0;
      repeat (2) @(negedge clk_i);
      wait_idle();
      chk("R5 new code visible", int'(bus_o), int'(val(n0 + 1)));
      chk("R5 oe", int'(bus_oe_o), 1);
      repeat (6) @(negedge clk_i);
      chk("R5 no second start", conv_num, n0 + 1);
      cs_ni = 1'b1; rd_ni = 1'b1;
      latch_exp = val(conv_num);
    end

    // continuous mode
    begin
      int n0;
      repeat (10) @(negedge clk_i);
      n0 = conv_num;
      cont_mode_ni = 1'b0;
      for (int i = 0; i < 4; i++) begin
        wait_busy();
        wait_idle();
        latch_exp = val(conv_num);
        chk("R8 code on completion", int'(bus_o), int'(latch_exp));
      end
      chk("R8 back to back", conv_num, n0 + 4);
    end

    // continuous mode, read active at completion
    begin
      int k;
      logic [7:0] old;
      wait_busy();
      repeat (2) @(negedge clk_i);
      k = conv_num;
      old = bus_o;
      cs_ni = 1'b0; rd_ni = 1'b0;
      wait_idle();
      chk("R9 load deferred", int'(bus_o), int'(old));
      repeat (20) @(negedge clk_i);
      chk("R9 busy held high", int'(busy_no), 1);
      chk("R9 stalled", conv_num, k);
      chk("R9 still old", int'(bus_o), int'(old));
      cs_ni = 1'b1; rd_ni = 1'b1;
      repeat (6) @(negedge clk_i);
      chk("R9 deferred code", int'(bus_o), int'(val(k)));
      chk("R9 restart", conv_num, k + 1);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_checks++; n_fail++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule